// File: doc/BRIEF.md
# Dual-Read Single-Write Register File with No-Access Identifier

This block holds the architectural registers of a small processor core. It has eight 32-bit entries. Two read ports each take a register identifier and return that entry's contents in the same cycle, with no clock in the path. One write port takes a destination identifier and a data word, and stores the word at the rising clock edge.

Identifiers are four bits wide. Values 0 to 7 select a real entry. Any value from 8 to 15 means "no register" on the port that receives it:

- A read port given such a value drives zero.
- The write port given such a value changes nothing.

Because of this, the instruction decoder can mute any port by sending the value 8, and no separate enable wires are needed.

A synchronous reset clears every entry to zero. A write to an entry is not forwarded to a read of that entry in the same cycle: the read shows the old contents until the clock edge.

Top module: `rf_multiport`

## Requirements
- R1: Each read port drives the current contents of the entry named by its identifier (0 to 7) in the same cycle, with no clock edge between an identifier change and the output change.
- R2: When the destination identifier is 0 to 7 and reset is low, the write data is stored in that entry at the rising clock edge and can be read from the next cycle on.
- R3: When the destination identifier is 8 to 15, a clock edge leaves all eight entries unchanged.
- R4: A read port whose identifier is 8 to 15 drives all-zero data.
- R5: A read of the entry being written in the same cycle returns the value held before the edge. The new value appears only after the edge.
- R6: While reset is high at a rising edge, every entry becomes zero. Reset takes priority over a write presented in the same cycle.
- R7: A write changes only the addressed entry. The other seven keep their values.
- R8: The two read ports are independent. Either may name any identifier, including the same entry as the other port or the one being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all entries |
| rd_a_id | input | 4 | Identifier for read port A (8 to 15 = no access) |
| rd_a_data | output | 32 | Read port A data |
| rd_b_id | input | 4 | Identifier for read port B (8 to 15 = no access) |
| rd_b_data | output | 32 | Read port B data |
| wr_id | input | 4 | Destination identifier (8 to 15 = no write) |
| wr_data | input | 32 | Data word to store |

## Verification
The bench builds the block with its default parameters: 32-bit entries, eight registers and 4-bit identifiers. With these values the seven unused codes, 9 to 15, can be driven as well as the reserved value 8, so every no-access alias is exercised on both read ports and on the write port.

Directed steps cover the following:
- a read of an entry in the same cycle it is being written;
- a write presented while reset is high;
- writes whose destination is an unused code.

Seeded pseudo-random traffic then mixes real and no-access identifiers on all three ports. Every cycle it is compared against a behavioural array model.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned RF_DATA_W  = 32;
    localparam int unsigned RF_NUM_REG = 8;
    localparam int unsigned RF_ID_W    = 4;

    // Access kind of one port after identifier decode
    typedef enum logic {
        ACC_NONE = 1'b0,
        ACC_REG  = 1'b1
    } acc_e;
endpackage

// File: rtl/rf_id_decode.sv
module rf_id_decode
    import rf_pkg::*;
#(
    parameter int unsigned ID_W     = RF_ID_W,
    parameter int unsigned NUM_REGS = RF_NUM_REG,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [ID_W-1:0]  id,
    output acc_e             kind,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        kind = (32'(id) < NUM_REGS) ? ACC_REG : ACC_NONE;
        idx  = id[IDX_W-1:0];
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W   = RF_DATA_W,
    parameter int unsigned NUM_REGS = RF_NUM_REG,
    parameter int unsigned ID_W     = RF_ID_W
) (
    input  logic [ID_W-1:0]                   id,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   regs,
    output logic [DATA_W-1:0]                 data
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    acc_e             kind;
    logic [IDX_W-1:0] idx;

    rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .id   (id),
        .kind (kind),
        .idx  (idx)
    );

    always_comb begin
        unique case (kind)
            ACC_REG:  data = regs[idx];
            ACC_NONE: data = '0;
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W   = RF_DATA_W,
    parameter int unsigned NUM_REGS = RF_NUM_REG,
    parameter int unsigned ID_W     = RF_ID_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ID_W-1:0]                   wr_id,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    acc_e             wr_kind;
    logic [IDX_W-1:0] wr_idx;

    rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .id   (wr_id),
        .kind (wr_kind),
        .idx  (wr_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            unique case (wr_kind)
                ACC_REG:  regs[wr_idx] <= wr_data;
                ACC_NONE: regs <= regs;
                default:  regs <= regs;
            endcase
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> regs == '0); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (32'(wr_id) < NUM_REGS) |=> regs[$past(wr_idx)] == $past(wr_data)); // R2

    AST_NULL_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (32'(wr_id) >= NUM_REGS) |=> $stable(regs)); // R3

    for (genvar e = 0; e < NUM_REGS; e++) begin : g_keep
        AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (rst)
            (32'(wr_id) != e) |=> $stable(regs[e])); // R7
    end
endmodule

// File: rtl/rf_multiport.sv
module rf_multiport
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W   = RF_DATA_W,
    parameter int unsigned NUM_REGS = RF_NUM_REG,
    parameter int unsigned ID_W     = RF_ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned NUM_RD = 2;
    localparam int unsigned IDX_W  = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NUM_RD-1:0][ID_W-1:0]     rd_ids;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_datas;

    assign rd_ids[0] = rd_a_id;
    assign rd_ids[1] = rd_b_id;
    assign rd_a_data = rd_datas[0];
    assign rd_b_data = rd_datas[1];

    rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_id   (wr_id),
        .wr_data (wr_data),
        .regs    (regs_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_port (
            .id   (rd_ids[p]),
            .regs (regs_q),
            .data (rd_datas[p])
        );

        AST_READ_TRACKS: assert property (@(posedge clk) disable iff (rst)
            (32'(rd_ids[p]) < NUM_REGS) |-> rd_datas[p] == regs_q[rd_ids[p][IDX_W-1:0]]); // R1

        AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
            (32'(rd_ids[p]) >= NUM_REGS) |-> rd_datas[p] == '0); // R4
    end

    AST_SAME_ID_AGREE: assert property (@(posedge clk) disable iff (rst)
        (rd_a_id == rd_b_id) |-> rd_a_data == rd_b_data); // R8
endmodule

// File: tb/sim_rf_multiport.sv
module sim_rf_multiport;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_id = 4'd8;
    logic [3:0]  rd_b_id = 4'd8;
    logic [3:0]  wr_id   = 4'd8;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a_data, rd_b_data;

    int unsigned model [8];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    rf_multiport u0 (
        .clk(clk), .rst(rst),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_id(wr_id), .wr_data(wr_data)
    );

    function automatic logic [31:0] expect_rd(input logic [3:0] id);
        return (id < 4'd8) ? model[id[2:0]] : 32'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle, compare before the edge, update the model at the edge
    task automatic step(input logic r, input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] w, input logic [31:0] d, input string tag);
        @(negedge clk);
        rst = r; rd_a_id = a; rd_b_id = b; wr_id = w; wr_data = d;
        #1;
        if (!r) begin
            check({tag, " portA"}, rd_a_data, expect_rd(a));
            check({tag, " portB"}, rd_b_data, expect_rd(b));
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 8; i++) model[i] = 0;
        end else if (w < 4'd8) begin
            model[w[2:0]] = d;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 32'hDEAD_0000;
        step(1'b1, 4'd8, 4'd8, 4'd8, 32'd0, "R6");
        step(1'b1, 4'd8, 4'd8, 4'd8, 32'd0, "R6");
        // R6: all entries zero after reset
        for (int i = 0; i < 8; i += 2)
            step(1'b0, 4'(i), 4'(i + 1), 4'd8, 32'd0, "R6 reset state");
        // R2/R7: fill every entry
        for (int i = 0; i < 8; i++)
            step(1'b0, 4'd8, 4'd8, 4'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101, "R2 fill");
        for (int i = 0; i < 8; i++)
            step(1'b0, 4'(i), 4'(7 - i), 4'd8, 32'd0, "R1 R7 readback");
        // R5: same-cycle read of written entry shows old value, new one next cycle
        step(1'b0, 4'd3, 4'd3, 4'd3, 32'hCAFE_F00D, "R5 before edge");
        step(1'b0, 4'd3, 4'd5, 4'd8, 32'd0, "R5 after edge");
        // R3: no-access destinations change nothing
        for (int w = 8; w < 16; w++)
            step(1'b0, 4'd8, 4'd8, 4'(w), 32'hFFFF_FFFF, "R3 null write");
        for (int i = 0; i < 8; i++)
            step(1'b0, 4'(i), 4'(i), 4'd8, 32'd0, "R3 R8 unchanged");
        // R4: every no-access read code drives zero
        for (int c = 8; c < 16; c++)
            step(1'b0, 4'(c), 4'(23 - c), 4'd1, 32'h0BAD_BEEF + 32'(c), "R4 null read");
        // R6: reset beats a simultaneous write
        step(1'b1, 4'd0, 4'd0, 4'd2, 32'h1234_5678, "R6 priority");
        for (int i = 0; i < 8; i += 2)
            step(1'b0, 4'(i), 4'(i + 1), 4'd8, 32'd0, "R6 cleared");
        // R8: mixed traffic on all ports
        for (int n = 0; n < 400; n++) begin
            logic [3:0] a, b, w;
            a = 4'($urandom_range(0, 11));
            b = 4'($urandom_range(0, 11));
            w = 4'($urandom_range(0, 10));
            step(1'b0, a, b, w, $urandom, "R1 R2 R8 mixed");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule